// File: doc/BRIEF.md
# Peripheral Clock Gate Bank with Set/Clear Control

This block gates one master clock into up to 64 separate peripheral clocks. Software controls the gates through a small register bus. For each bank of 32 peripherals there are three registers. The first is a write-one-to-enable register. The second is a write-one-to-disable register. The third is a read-only register that shows which clocks are currently running. Because setting and clearing use separate registers, one driver can start or stop its own peripheral without a read-modify-write. That write cannot disturb the gates that other software owns.

A peripheral's number selects its bank and its bit. Numbers 0 to 31 belong to bank 0 and numbers 32 to 63 belong to bank 1. The bit position inside a bank is the number modulo 32. The two lowest numbers are reserved for peripherals that must never stop: their gates are always open and writes to them do nothing.

Each peripheral gets a level enable and a gated clock. The enable that feeds the gate is re-timed on the falling edge of the master clock. As a result, a gated clock only ever starts or stops with a whole pulse.

Top module: `pclk_gate_bank`

## Requirements
- R1: After reset, the enables of peripherals 2 to 63 are 0. Reading the bank 0 status register returns 0x00000003 and reading the bank 1 status register returns 0x00000000.
- R2: Writing the set register of a bank turns on every peripheral whose bit is 1 in the write data. Bits written as 0 leave their peripherals unchanged.
- R3: Writing the clear register of a bank turns off every peripheral whose bit is 1 in the write data. Bits written as 0 leave their peripherals unchanged.
- R4: The address is {bank, register}. The bank is addr[2], with 0 selecting peripherals 0 to 31 and 1 selecting 32 to 63. The register is addr[1:0]: 0 is set, 1 is clear, 2 is status. Bit k of a bank stands for peripheral 32*bank + k. A status read while rd_en is high returns the current enables of that bank in the same cycle.
- R5: Peripherals 0 and 1 are always enabled. Their status bits read 1, and set or clear writes to them have no effect.
- R6: A read of a set register, a clear register or register code 3 returns 0. When rd_en is low, rdata is 0.
- R7: When a peripheral is enabled, its gated clock follows the master clock with full-width high pulses. When it is disabled, its gated clock stays low. A new enable value reaches the gate only at a falling edge of the master clock, so no pulse is ever shortened.
- R8: A write to one bank leaves every enable of the other bank unchanged. Enables do not change in a cycle without a write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe, sampled on the rising edge |
| rd_en | input | 1 | Read strobe, combinational read |
| addr | input | 3 | {bank, register code} |
| wdata | input | 32 | Write data, one bit per peripheral of the bank |
| rdata | output | 32 | Read data |
| per_en | output | 64 | Current enable of each peripheral |
| per_clk | output | 64 | Gated clock of each peripheral |

## Verification
The bench writes masks that mix 1 and 0 bits. A design that treated a set or clear write as a plain store would then lose bits that were already on or already off. It aims writes at peripherals 0 and 1 and at peripheral 32. A design with the wrong mask would either let a reserved clock be stopped or fail to gate peripheral 32. It also reads back the write-only registers and the opposite bank after each write, to catch a read mux that leaks state or a bank decode that hits both banks. Finally, it counts gated-clock pulses and measures every high time while it toggles one gate repeatedly. A gate that used the rising-edge enable directly would produce short or missing pulses, and both would show up in those measurements.

// File: rtl/pclk_gate_bank.sv
module pclk_gate_bank #(
  parameter int BANKS = 2,
  parameter int BW    = 32,
  parameter int FIXED = 2,
  localparam int N    = BANKS * BW,
  localparam int AW   = $clog2(BANKS) + 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [AW-1:0] addr,
  input  logic [BW-1:0] wdata,
  output logic [BW-1:0] rdata,
  output logic [N-1:0]  per_en,
  output logic [N-1:0]  per_clk
);

  localparam logic [1:0] SEL_SET = 2'd0;
  localparam logic [1:0] SEL_CLR = 2'd1;
  localparam logic [1:0] SEL_STS = 2'd2;
  localparam logic [N-1:0] KEEP = {{(N-FIXED){1'b0}}, {FIXED{1'b1}}};

  logic [BW-1:0] en_q [BANKS];
  logic [N-1:0]  en_fall;
  wire  [1:0]    sel = addr[1:0];

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    localparam logic [BW-1:0] KB = KEEP[b*BW +: BW];
    wire hit = wr_en && (addr[AW-1:2] == b);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        en_q[b] <= KB;
      else if (hit && sel == SEL_SET)
        en_q[b] <= en_q[b] | wdata | KB;
      else if (hit && sel == SEL_CLR)
        en_q[b] <= (en_q[b] & ~wdata) | KB;
    end

    assign per_en[b*BW +: BW] = en_q[b];

    a_r2_set_takes: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == {b[AW-3:0], SEL_SET}) |=>
        ((per_en[b*BW +: BW] & $past(wdata)) == $past(wdata)));

    a_r3_clear_takes: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == {b[AW-3:0], SEL_CLR}) |=>
        ((per_en[b*BW +: BW] & $past(wdata) & ~KB) == '0));

    a_r8_other_bank_kept: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_en || addr[AW-1:2] != b) |=> $stable(per_en[b*BW +: BW]));
  end

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) en_fall <= KEEP;
    else        en_fall <= per_en;
  end

  assign per_clk = {N{clk}} & en_fall;

  always_comb begin
    rdata = '0;
    if (rd_en && sel == SEL_STS) rdata = en_q[addr[AW-1:2]];
  end

  a_r5_fixed_on: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr[AW-1:2] == '0 && sel == SEL_STS) |-> (&rdata[FIXED-1:0]));

  a_r6_wo_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_en || sel != SEL_STS) |-> (rdata == '0));

  a_r7_gate_follows_fall: assert property (@(negedge clk) disable iff (!rst_n)
    1'b1 |=> (en_fall == $past(per_en)));

endmodule

// File: tb/pclk_gate_bank_tb.sv
module pclk_gate_bank_tb;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        wr_en = 0, rd_en = 0;
  logic [2:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [63:0] per_en, per_clk;

  int checks = 0, failures = 0;
  int c0 = 0, c5 = 0, c7 = 0, runts = 0, c40 = 0;
  realtime t40 = 0;

  always #10 clk = ~clk;

  pclk_gate_bank u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .per_en(per_en), .per_clk(per_clk)
  );

  always @(posedge per_clk[0]) c0++;
  always @(posedge per_clk[5]) c5++;
  always @(posedge per_clk[7]) c7++;
  always @(posedge per_clk[40]) begin t40 = $realtime; c40++; end
  always @(negedge per_clk[40]) if ($realtime - t40 != 10) runts++;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1; addr = a; wdata = d;
    @(negedge clk); wr_en = 0; wdata = '0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); rd_en = 1; addr = a;
    #2 d = rdata;
    rd_en = 0;
  endtask

  task automatic t_reset;
    logic [31:0] d;
    chk("R1 per_en", per_en, 64'h3);
    rd(3'b010, d); chk("R1 status0", d, 32'h3);
    rd(3'b110, d); chk("R1 status1", d, 32'h0);
  endtask

  task automatic t_set_clear;
    logic [31:0] d;
    wr(3'b000, 32'h0000_00A0);
    rd(3'b010, d); chk("R2 set 5,7", d, 32'hA3);
    wr(3'b000, 32'h0000_0000);
    rd(3'b010, d); chk("R2 zero bits no effect", d, 32'hA3);
    wr(3'b001, 32'h0000_0020);
    rd(3'b010, d); chk("R3 clear 5", d, 32'h83);
    wr(3'b001, 32'h0000_0000);
    rd(3'b010, d); chk("R3 zero bits no effect", d, 32'h83);
  endtask

  task automatic t_bank1;
    logic [31:0] d;
    wr(3'b100, 32'h8000_0101);
    rd(3'b110, d); chk("R4 status1 ids 32,40,63", d, 32'h8000_0101);
    chk("R4 per_en bank1", per_en[63:32], 64'h8000_0101);
    rd(3'b010, d); chk("R8 bank0 untouched", d, 32'h83);
    wr(3'b001, 32'hFFFF_FFFF);
    rd(3'b110, d); chk("R8 bank1 untouched by bank0 clear", d, 32'h8000_0101);
    rd(3'b010, d); chk("R5 fixed ids survive clear", d, 32'h3);
    chk("R5 per_en fixed", per_en[1:0], 64'h3);
    wr(3'b101, 32'h0000_0001);
    rd(3'b110, d); chk("R4 id 32 gateable", d, 32'h8000_0100);
  endtask

  task automatic t_readzero;
    logic [31:0] d;
    rd(3'b000, d); chk("R6 set reads 0", d, 0);
    rd(3'b001, d); chk("R6 clear reads 0", d, 0);
    rd(3'b111, d); chk("R6 code 3 reads 0", d, 0);
    @(negedge clk); addr = 3'b010; #2 chk("R6 rd_en low gives 0", rdata, 0);
  endtask

  task automatic t_gating;
    wr(3'b000, 32'h0000_0080);
    c0 = 0; c5 = 0; c7 = 0;
    repeat (8) @(negedge clk);
    chk("R7 id 7 pulses", c7, 8);
    chk("R7 id 5 stays low", c5, 0);
    chk("R5 id 0 pulses", c0, 8);
    for (int i = 0; i < 6; i++) begin
      wr(3'b100, 32'h0000_0100);
      repeat (i % 3) @(negedge clk);
      wr(3'b101, 32'h0000_0100);
    end
    c40 = 0;
    repeat (4) @(negedge clk);
    chk("R7 id 40 off after clear", c40, 0);
    chk("R7 no runt pulses on id 40", runts, 0);
  endtask

  initial begin
    #100000;
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset;
    t_set_clear;
    t_bank1;
    t_readzero;
    t_gating;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule